// File: doc/BRIEF.md
# Read-Address Command Sequence Detector

This block sits beside a memory array's access port and picks hidden commands out of ordinary read traffic. A command is six reads in a row to a fixed chain of addresses. The first five addresses are the same for every command. The sixth address chooses which command fires: store, recall or autostore enable. Each access is marked by a strobe, qualified as a read or a write, and carries a 16-bit low address.

When the sixth matching read is accepted, the block raises one of three command outputs for exactly one clock. The surrounding logic then starts the transfer and blocks normal access. While that command runs, the surrounding logic holds `busy_i` high, and the detector ignores all traffic.

A write anywhere in the chain cancels the progress made so far. A read to an address that is off the chain also cancels it. The one exception is a stray read to the first chain address, which counts as a fresh first step.

Top module: `nvcmd_seq_detect`

## Requirements
- R1: While `rst_ni` is low, all three command outputs are low and the progress through the chain returns to idle. A reset in the middle of a chain means the rest of that chain does not fire.
- R2: The chain advances only on read accesses (`acc_valid_i`=1, `acc_write_i`=0) whose addresses arrive in this exact order: 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F.
- R3: A sixth read to address 0x8FC0, following the five chain reads, raises `cmd_store_o`. It is high in the clock cycle after the edge that samples that read, and only in that cycle.
- R4: A sixth read to address 0x4C63 raises `cmd_recall_o` with the same timing as R3.
- R5: A sixth read to address 0x4B46 raises `cmd_auto_en_o` with the same timing as R3.
- R6: Any accepted write access returns the progress to idle. The chain must then restart from 0x4E38.
- R7: A read whose address does not match the next expected entry returns the progress to idle. This includes a sixth address that selects no command. If that address is 0x4E38, it counts as the first step of a new chain.
- R8: Cycles with `acc_valid_i` low do not change the progress, whatever the other inputs are.
- R9: While `busy_i` is high, accesses are ignored. The progress is held unchanged, and no command output rises in the following cycle.
- R10: At most one command output is high in any cycle, and no command output is high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | One access this cycle |
| acc_write_i | input | 1 | 1 = write access, 0 = read access |
| acc_addr_i | input | 16 | Low address field of the access |
| busy_i | input | 1 | A command is currently executing |
| cmd_store_o | output | 1 | One-cycle store command pulse |
| cmd_recall_o | output | 1 | One-cycle recall command pulse |
| cmd_auto_en_o | output | 1 | One-cycle autostore-enable command pulse |

## Verification
Each command output is due exactly one cycle after the rising edge that samples the sixth read. An access that is aborted or ignored shows up only in the cycle after the sixth read would later have completed a command.

The bench drives inputs on the falling edge and steps its reference model at the next rising edge. It compares all three outputs at the following falling edge, so every cycle carries a check of the one-cycle latency. Effects on progress that cannot be seen directly, such as holding, aborting or restarting, are checked by finishing or continuing the chain afterwards and checking whether the expected pulse appears or stays absent.

// File: rtl/nvseq_pkg.sv
package nvseq_pkg;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned PREFIX_LEN = 5;
  localparam int unsigned NUM_CMD    = 3;
  localparam int unsigned STEP_W     = $clog2(PREFIX_LEN + 1);

  // command index order on the tail vector
  localparam int unsigned CMD_STORE  = 0;
  localparam int unsigned CMD_RECALL = 1;
  localparam int unsigned CMD_AUTO   = 2;

  function automatic logic [ADDR_W-1:0] prefix_addr(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    return 16'h4E38;
      3'd1:    return 16'hB1C7;
      3'd2:    return 16'h83E0;
      3'd3:    return 16'h7C1F;
      3'd4:    return 16'h703F;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/nvseq_match.sv
module nvseq_match
  import nvseq_pkg::*;
#(
  parameter logic [NUM_CMD*ADDR_W-1:0] TAILS = {16'h4B46, 16'h4C63, 16'h8FC0}
) (
  input  logic [STEP_W-1:0]  step_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               hit_next_o,
  output logic               hit_first_o,
  output logic [NUM_CMD-1:0] tail_hit_o
);
  assign hit_next_o  = (step_i < STEP_W'(PREFIX_LEN)) && (addr_i == prefix_addr(step_i));
  assign hit_first_o = (addr_i == prefix_addr('0));

  for (genvar g = 0; g < NUM_CMD; g++) begin : g_tail
    assign tail_hit_o[g] = (addr_i == TAILS[g*ADDR_W +: ADDR_W]);
  end
endmodule

// File: rtl/nvseq_tracker.sv
module nvseq_tracker
  import nvseq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic              busy_i,
  input  logic              hit_next_i,
  input  logic              hit_first_i,
  input  logic              tail_any_i,
  output logic [STEP_W-1:0] step_o,
  output logic              fire_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(PREFIX_LEN);

  logic [STEP_W-1:0] step_q, step_d;
  logic              take_rd, take_wr;

  assign take_rd = acc_valid_i && !busy_i && !acc_write_i;
  assign take_wr = acc_valid_i && !busy_i &&  acc_write_i;
  assign fire_o  = take_rd && (step_q == LAST) && tail_any_i;

  always_comb begin
    step_d = step_q;
    if (take_wr) begin
      step_d = '0;
    end else if (take_rd) begin
      if (hit_next_i)       step_d = step_q + 1'b1;
      else if (fire_o)      step_d = '0;
      else if (hit_first_i) step_d = STEP_W'(1);
      else                  step_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= '0;
    else         step_q <= step_d;
  end

  assign step_o = step_q;

  p_step_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q <= LAST);
  p_write_abort_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i && !busy_i) |=> (step_q == '0));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(step_q));
  p_busy_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(step_q));
endmodule

// File: rtl/nvseq_pulse.sv
module nvseq_pulse
  import nvseq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fire_i,
  input  logic [NUM_CMD-1:0] tail_hit_i,
  output logic [NUM_CMD-1:0] cmd_o
);
  logic [NUM_CMD-1:0] cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmd_q <= '0;
    else if (fire_i) cmd_q <= tail_hit_i;
    else             cmd_q <= '0;
  end

  assign cmd_o = cmd_q;

  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_q));
  p_single_cycle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|cmd_q) |=> !(|cmd_q));
endmodule

// File: rtl/nvcmd_seq_detect.sv
module nvcmd_seq_detect
  import nvseq_pkg::*;
#(
  parameter logic [ADDR_W-1:0] STORE_TAIL  = 16'h8FC0,
  parameter logic [ADDR_W-1:0] RECALL_TAIL = 16'h4C63,
  parameter logic [ADDR_W-1:0] AUTO_TAIL   = 16'h4B46
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_valid_i,
  input  logic              acc_write_i,
  input  logic [ADDR_W-1:0] acc_addr_i,
  input  logic              busy_i,
  output logic              cmd_store_o,
  output logic              cmd_recall_o,
  output logic              cmd_auto_en_o
);
  localparam logic [NUM_CMD*ADDR_W-1:0] TAILS = {AUTO_TAIL, RECALL_TAIL, STORE_TAIL};

  logic [STEP_W-1:0]  step;
  logic               hit_next, hit_first, fire;
  logic [NUM_CMD-1:0] tail_hit, cmd;

  nvseq_match #(.TAILS(TAILS)) u_match (
    .step_i      (step),
    .addr_i      (acc_addr_i),
    .hit_next_o  (hit_next),
    .hit_first_o (hit_first),
    .tail_hit_o  (tail_hit)
  );

  nvseq_tracker u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_valid_i (acc_valid_i),
    .acc_write_i (acc_write_i),
    .busy_i      (busy_i),
    .hit_next_i  (hit_next),
    .hit_first_i (hit_first),
    .tail_any_i  (|tail_hit),
    .step_o      (step),
    .fire_o      (fire)
  );

  nvseq_pulse u_pulse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fire_i     (fire),
    .tail_hit_i (tail_hit),
    .cmd_o      (cmd)
  );

  assign cmd_store_o   = cmd[CMD_STORE];
  assign cmd_recall_o  = cmd[CMD_RECALL];
  assign cmd_auto_en_o = cmd[CMD_AUTO];

  p_busy_no_cmd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> !(cmd_store_o || cmd_recall_o || cmd_auto_en_o));
  p_write_no_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_valid_i && acc_write_i) |=> !(cmd_store_o || cmd_recall_o || cmd_auto_en_o));
endmodule

// File: tb/nvcmd_seq_detect_tb_top.sv
`timescale 1ns/1ps
module nvcmd_seq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0, wr = 1'b0, busy = 1'b0;
  logic [15:0] addr = '0;
  logic        o_st, o_rc, o_ae;

  int checks = 0;
  int errors = 0;
  int m_step = 0;
  logic [2:0] exp_cmd = '0;

  always #2 clk = ~clk;

  nvcmd_seq_detect dut_i (
    .clk_i(clk), .rst_ni(rst_n), .acc_valid_i(valid), .acc_write_i(wr),
    .acc_addr_i(addr), .busy_i(busy),
    .cmd_store_o(o_st), .cmd_recall_o(o_rc), .cmd_auto_en_o(o_ae)
  );

  function automatic logic [15:0] pref(input int i);
    case (i)
      0: return 16'h4E38; 1: return 16'hB1C7; 2: return 16'h83E0;
      3: return 16'h7C1F; default: return 16'h703F;
    endcase
  endfunction

  // index 0 store, 1 recall, 2 autostore enable
  function automatic logic [15:0] tail(input int k);
    case (k)
      0: return 16'h8FC0; 1: return 16'h4C63; default: return 16'h4B46;
    endcase
  endfunction

  task automatic model(input logic v, input logic w, input logic [15:0] a, input logic b);
    exp_cmd = '0;
    if (v && !b) begin
      if (w) m_step = 0;
      else if (m_step < 5) begin
        if (a == pref(m_step)) m_step++;
        else if (a == pref(0)) m_step = 1;
        else m_step = 0;
      end else begin
        for (int k = 0; k < 3; k++) if (a == tail(k)) exp_cmd[k] = 1'b1;
        if (exp_cmd != 0) m_step = 0;
        else if (a == pref(0)) m_step = 1;
        else m_step = 0;
      end
    end
  endtask

  task automatic check(input string tag);
    checks++;
    if ({o_ae, o_rc, o_st} !== exp_cmd) begin
      errors++;
      $display("FAIL %s: actual {ae,rc,st}=%b expected %b at %0t", tag, {o_ae, o_rc, o_st}, exp_cmd, $time);
    end
  endtask

  task automatic cyc(input logic v, input logic w, input logic [15:0] a, input logic b, input string tag);
    valid = v; wr = w; addr = a; busy = b;
    @(posedge clk);
    model(v, w, a, b);
    @(negedge clk);
    check(tag);
  endtask

  task automatic rd(input logic [15:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 1'b0, tag);
  endtask

  task automatic prefix_n(input int n, input string tag);
    for (int i = 0; i < n; i++) rd(pref(i), tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    exp_cmd = '0;
    check("R1 outputs low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs low after reset");

    // R3 R4 R5: each command
    for (int k = 0; k < 3; k++) begin
      prefix_n(5, "R2 prefix");
      rd(tail(k), k == 0 ? "R3 store" : (k == 1 ? "R4 recall" : "R5 autostore"));
      cyc(1'b0, 1'b0, 16'h0, 1'b0, "R10 pulse one cycle");
    end

    // R6 write mid chain
    prefix_n(3, "R6 setup");
    cyc(1'b1, 1'b1, pref(3), 1'b0, "R6 write");
    for (int i = 3; i < 5; i++) rd(pref(i), "R6 resume");
    rd(tail(0), "R6 no pulse after write");

    // R7 wrong address then restart on first entry
    prefix_n(3, "R7 setup");
    rd(16'h1234, "R7 mismatch");
    for (int i = 3; i < 5; i++) rd(pref(i), "R7 resume");
    rd(tail(1), "R7 no pulse after mismatch");
    prefix_n(2, "R7 setup2");
    rd(pref(0), "R7 restart step one");
    for (int i = 1; i < 5; i++) rd(pref(i), "R7 continue");
    rd(tail(2), "R7 pulse after restart");
    prefix_n(5, "R7 setup3");
    rd(16'hFFFF, "R7 bad sixth");
    rd(tail(0), "R7 no pulse after bad sixth");

    // R8 idle cycles hold progress
    prefix_n(4, "R8 setup");
    cyc(1'b0, 1'b1, 16'hDEAD, 1'b0, "R8 idle write ignored");
    cyc(1'b0, 1'b0, 16'h0000, 1'b0, "R8 idle");
    rd(pref(4), "R8 resume");
    rd(tail(0), "R8 pulse after idle");

    // R9 busy holds progress and blocks firing
    prefix_n(5, "R9 setup");
    cyc(1'b1, 1'b0, tail(0), 1'b1, "R9 busy sixth ignored");
    cyc(1'b1, 1'b1, 16'h0, 1'b1, "R9 busy write ignored");
    rd(tail(1), "R9 pulse after busy");

    // R1 reset mid chain
    prefix_n(5, "R1 setup");
    rst_n = 1'b0; m_step = 0;
    @(negedge clk);
    exp_cmd = '0;
    check("R1 reset mid chain");
    rst_n = 1'b1;
    rd(tail(0), "R1 no pulse after reset");

    // random traffic, biased toward the expected next address (R10)
    for (int n = 0; n < 4000; n++) begin
      int r = int'($urandom_range(0, 99));
      logic v = (r < 85);
      logic w = ($urandom_range(0, 99) < 5);
      logic b = ($urandom_range(0, 99) < 5);
      logic [15:0] a;
      int s = int'($urandom_range(0, 99));
      if (s < 80) a = (m_step < 5) ? pref(m_step) : tail(int'($urandom_range(0, 2)));
      else if (s < 88) a = pref(0);
      else a = 16'($urandom);
      cyc(v, w, a, b, "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule